// File: doc/BRIEF.md
# Back-End Stage Flow Controller

This block sequences the flow of instruction bundles through one out-of-order back-end stage that sits between a rename stage and a commit stage. It keeps the stage in one of five states and decides, every cycle, whether the incoming rename bundle is handed straight on, parked, or discarded. When the stage must hold, incoming bundles are saved in a small skid FIFO. Later they are replayed one per cycle, in arrival order. The stall to rename is held until that replay has finished.

Squash requests from commit are turned into three commands toward the issue queue: a one-cycle start, a continue level, and a one-cycle stop. The issue queue's free-entry count is forwarded upstream without change. The issue queue, load/store queue and execution units are outside the block. They appear only as the full flag, the free count and the squash command ports.

Top module: `stage_flow_ctrl`

## Requirements
- R1: While the active-low reset `rst_n` is low, the controller is held in Idle (status code 0), the skid FIFO is empty, `skid_ovf` is 0 and `up_stall` is 0.
- R2: In Idle (0) or Running (1), a valid bundle that arrives with no commit stall, no squash and the issue queue not full is presented on `proc_bundle` with `proc_vld` high in the same cycle. From Idle the status then becomes Running (1).
- R3: In Idle, Running or Unblocking, a commit stall, or a valid bundle while `iq_full` is high, moves the status to Blocked (2) on the next cycle. Any valid bundle of that cycle is saved in the skid FIFO and not presented. In Blocked, every valid bundle is saved.
- R4: In Blocked, `up_stall` is high every cycle. The status moves to Unblocking (3) only after a cycle in which the commit stall is low and `iq_full` is low.
- R5: In Unblocking, one saved bundle per cycle is presented on `proc_bundle`, oldest first. `up_stall` stays high except in the cycle that removes the last entry (or finds the FIFO empty), after which the status is Running (1).
- R6: A commit squash or a reorder-buffer-squashing indication in Idle, Running, Unblocking or Blocked raises `iq_squash_start` for that cycle and moves the status to Squashing (4). The bundle of that cycle is discarded.
- R7: In Squashing, `iq_squash_cont` is high in every cycle that either squash indication is high. The first cycle with both low raises `iq_squash_stop` for one cycle, and the status returns to Running. Bundles are ignored and `up_stall` is low in Squashing.
- R8: Outside Squashing and Blocked, a commit stall that arrives together with a squash indication wins. The status goes to Blocked and no squash start is issued.
- R9: Entering Squashing empties the skid FIFO, so no bundle saved before the squash is ever presented.
- R10: A bundle that must be saved while the FIFO already holds `SKID_DEPTH` entries (default 4) and none is removed that cycle is dropped. `skid_ovf` goes high on the next cycle and stays high until reset.
- R11: `up_free_cnt` equals `iq_free_cnt` in every cycle, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_vld | input | 1 | Rename bundle valid |
| ren_bundle | input | BUNDLE_W | Rename bundle payload |
| cmt_stall | input | 1 | Stall request from commit |
| cmt_squash | input | 1 | Squash request from commit |
| rob_squashing | input | 1 | Reorder buffer is squashing |
| iq_full | input | 1 | Issue queue full |
| iq_free_cnt | input | FREE_W | Issue queue free entries |
| up_stall | output | 1 | Stall toward rename |
| up_free_cnt | output | FREE_W | Free-entry count forwarded to rename |
| proc_vld | output | 1 | A bundle is handed on this cycle |
| proc_bundle | output | BUNDLE_W | Bundle handed on (direct or replayed) |
| iq_squash_start | output | 1 | One-cycle squash start to issue queue |
| iq_squash_cont | output | 1 | Squash continue to issue queue |
| iq_squash_stop | output | 1 | One-cycle squash stop to issue queue |
| skid_ovf | output | 1 | Sticky skid FIFO overflow flag |
| stage_status | output | 3 | Current status code |

## Verification
The embedded properties watch, on every cycle, that Blocked always stalls rename, that Unblocking with more than one saved entry keeps the stall, that squash commands are mutually exclusive, that a start is issued only under a squash indication and always lands in Squashing, and that overflow sets the sticky flag. Order and content of replayed bundles, and the absence of stale entries after a squash flush, can only be shown by the bench's scenarios. There a scoreboard matches every presented bundle against the bundles the stimulus expects to survive. The same applies to the stall-over-squash priority and to the exact cycle in which the stall drops.

// File: rtl/stage_flow_pkg.sv
package stage_flow_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUNNING = 3'd1,
    ST_BLOCKED = 3'd2,
    ST_UNBLOCK = 3'd3,
    ST_SQUASH  = 3'd4
  } flow_state_e;

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/skid_fifo.sv
module skid_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = stage_flow_pkg::ptr_width(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              ovf
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              full, empty, do_wr, do_rd;

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign do_rd = pop && !empty && !flush;
  assign do_wr = push && !flush && (!full || do_rd);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_wr) wptr_d = (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
      if (do_rd) rptr_d = (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
      if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
      if (push && !do_wr) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= din;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> ovf_q);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/flow_fsm.sv
module flow_fsm
  import stage_flow_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ren_vld,
  input  logic             cmt_stall,
  input  logic             cmt_squash,
  input  logic             rob_squashing,
  input  logic             iq_full,
  input  logic [CNT_W-1:0] skid_cnt,
  output flow_state_e      state,
  output logic             push,
  output logic             pop,
  output logic             flush,
  output logic             pass_vld,
  output logic             up_stall,
  output logic             sq_start,
  output logic             sq_cont,
  output logic             sq_stop
);

  flow_state_e state_q, state_d;
  logic        sq_any, hold;

  assign sq_any = cmt_squash || rob_squashing;
  assign hold   = cmt_stall || (ren_vld && iq_full);

  always_comb begin
    state_d  = state_q;
    push     = 1'b0;
    pop      = 1'b0;
    flush    = 1'b0;
    pass_vld = 1'b0;
    up_stall = 1'b0;
    sq_start = 1'b0;
    sq_cont  = 1'b0;
    sq_stop  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_RUNNING: begin
        if (hold) begin
          state_d = ST_BLOCKED;
          push    = ren_vld;
        end else if (sq_any) begin
          state_d  = ST_SQUASH;
          sq_start = 1'b1;
        end else if (ren_vld) begin
          pass_vld = 1'b1;
          state_d  = ST_RUNNING;
        end
      end
      ST_BLOCKED: begin
        up_stall = 1'b1;
        if (sq_any) begin
          state_d  = ST_SQUASH;
          sq_start = 1'b1;
          flush    = 1'b1;
        end else begin
          push = ren_vld;
          if (!cmt_stall && !iq_full) state_d = ST_UNBLOCK;
        end
      end
      ST_UNBLOCK: begin
        if (hold) begin
          state_d  = ST_BLOCKED;
          push     = ren_vld;
          up_stall = 1'b1;
        end else if (sq_any) begin
          state_d  = ST_SQUASH;
          sq_start = 1'b1;
          flush    = 1'b1;
        end else begin
          pop  = (skid_cnt != '0);
          push = ren_vld;
          if (!ren_vld && (skid_cnt <= CNT_W'(1))) state_d = ST_RUNNING;
          else up_stall = 1'b1;
        end
      end
      ST_SQUASH: begin
        if (sq_any) begin
          sq_cont = 1'b1;
        end else begin
          sq_stop = 1'b1;
          state_d = ST_RUNNING;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R4
  blocked_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLOCKED) |-> up_stall);

  // R5
  unblock_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNBLOCK && skid_cnt > CNT_W'(1) && !sq_any) |-> up_stall);

  // R6
  squash_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_start |-> (sq_any && !(cmt_stall && state_q != ST_BLOCKED)));

  // R6
  squash_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_start |=> (state_q == ST_SQUASH));

  // R7
  squash_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sq_start, sq_cont, sq_stop}));

  // R7
  squash_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_stop |=> (state_q == ST_RUNNING));

endmodule

// File: rtl/stage_flow_ctrl.sv
module stage_flow_ctrl
  import stage_flow_pkg::*;
#(
  parameter int unsigned BUNDLE_W   = 32,
  parameter int unsigned SKID_DEPTH = 4,
  parameter int unsigned FREE_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ren_vld,
  input  logic [BUNDLE_W-1:0] ren_bundle,
  input  logic                cmt_stall,
  input  logic                cmt_squash,
  input  logic                rob_squashing,
  input  logic                iq_full,
  input  logic [FREE_W-1:0]   iq_free_cnt,
  output logic                up_stall,
  output logic [FREE_W-1:0]   up_free_cnt,
  output logic                proc_vld,
  output logic [BUNDLE_W-1:0] proc_bundle,
  output logic                iq_squash_start,
  output logic                iq_squash_cont,
  output logic                iq_squash_stop,
  output logic                skid_ovf,
  output logic [2:0]          stage_status
);

  localparam int unsigned CNT_W = $clog2(SKID_DEPTH + 1);

  flow_state_e       state;
  logic              push, pop, flush, pass_vld;
  logic [CNT_W-1:0]  skid_cnt;
  logic [BUNDLE_W-1:0] skid_head;

  flow_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ren_vld       (ren_vld),
    .cmt_stall     (cmt_stall),
    .cmt_squash    (cmt_squash),
    .rob_squashing (rob_squashing),
    .iq_full       (iq_full),
    .skid_cnt      (skid_cnt),
    .state         (state),
    .push          (push),
    .pop           (pop),
    .flush         (flush),
    .pass_vld      (pass_vld),
    .up_stall      (up_stall),
    .sq_start      (iq_squash_start),
    .sq_cont       (iq_squash_cont),
    .sq_stop       (iq_squash_stop)
  );

  skid_fifo #(.DEPTH(SKID_DEPTH), .DATA_W(BUNDLE_W)) u_skid (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .flush (flush),
    .din   (ren_bundle),
    .head  (skid_head),
    .count (skid_cnt),
    .ovf   (skid_ovf)
  );

  assign proc_vld     = pass_vld || pop;
  assign proc_bundle  = pop ? skid_head : ren_bundle;
  assign up_free_cnt  = iq_free_cnt;
  assign stage_status = state;

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iq_squash_start |=> (skid_cnt == '0));

  // R7
  squash_no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SQUASH) |-> (!proc_vld && !up_stall));

endmodule

// File: tb/stage_flow_ctrl_tb.sv
module stage_flow_ctrl_tb;

  localparam int BW = 32;
  localparam int FW = 6;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ren_vld, cmt_stall, cmt_squash, rob_squashing, iq_full;
  logic [BW-1:0] ren_bundle;
  logic [FW-1:0] iq_free_cnt;
  logic          up_stall, proc_vld, sq_start, sq_cont, sq_stop, skid_ovf;
  logic [FW-1:0] up_free_cnt;
  logic [BW-1:0] proc_bundle;
  logic [2:0]    status;

  int n_tests = 0;
  int n_fail  = 0;
  logic [BW-1:0] exp_q[$];

  always #2 clk = ~clk;

  stage_flow_ctrl #(.BUNDLE_W(BW), .SKID_DEPTH(DEPTH), .FREE_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ren_vld(ren_vld), .ren_bundle(ren_bundle),
    .cmt_stall(cmt_stall), .cmt_squash(cmt_squash), .rob_squashing(rob_squashing),
    .iq_full(iq_full), .iq_free_cnt(iq_free_cnt), .up_stall(up_stall),
    .up_free_cnt(up_free_cnt), .proc_vld(proc_vld), .proc_bundle(proc_bundle),
    .iq_squash_start(sq_start), .iq_squash_cont(sq_cont), .iq_squash_stop(sq_stop),
    .skid_ovf(skid_ovf), .stage_status(status)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, then settle before sampling
  task automatic step(input logic v, input logic [BW-1:0] d, input logic st,
                      input logic sq, input logic rb, input logic fl, input logic keep);
    @(negedge clk);
    ren_vld = v; ren_bundle = d; cmt_stall = st; cmt_squash = sq;
    rob_squashing = rb; iq_full = fl;
    iq_free_cnt = FW'(($urandom % 60) + 1);
    if (keep) exp_q.push_back(d);
    #1.5;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n === 1'b1) begin
        chk("R11", "free count forward", int'(up_free_cnt), int'(iq_free_cnt));
        if (proc_vld) begin
          if (exp_q.size() == 0) begin
            chk("R5", "unexpected bundle", int'(proc_bundle), -1);
          end else begin
            logic [BW-1:0] e;
            e = exp_q.pop_front();
            chk("R5", "bundle order", int'(proc_bundle), int'(e));
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ren_vld = 0; ren_bundle = '0; cmt_stall = 0; cmt_squash = 0;
    rob_squashing = 0; iq_full = 0; iq_free_cnt = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset status", int'(status), 0);
    chk("R1", "reset stall", int'(up_stall), 0);
    chk("R1", "reset ovf", int'(skid_ovf), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: first bundles from Idle pass through
    step(1, 32'hA1, 0, 0, 0, 0, 1);
    chk("R2", "idle status", int'(status), 0);
    chk("R2", "pass vld", int'(proc_vld), 1);
    step(1, 32'hA2, 0, 0, 0, 0, 1);
    chk("R2", "running status", int'(status), 1);
    step(1, 32'hA3, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R2", "running idle cycle no vld", int'(proc_vld), 0);

    // R3/R4/R5: commit stall blocks, replay in order
    step(1, 32'hB1, 1, 0, 0, 0, 1);
    chk("R3", "held bundle not passed", int'(proc_vld), 0);
    step(1, 32'hB2, 1, 0, 0, 0, 1);
    chk("R3", "blocked status", int'(status), 2);
    chk("R4", "blocked stall", int'(up_stall), 1);
    step(1, 32'hB3, 1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R4", "still blocked on release cycle", int'(status), 2);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R5", "unblocking status", int'(status), 3);
    chk("R5", "stall with 3 saved", int'(up_stall), 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R5", "stall with 2 saved", int'(up_stall), 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R5", "stall drops on last pop", int'(up_stall), 0);
    chk("R5", "last pop vld", int'(proc_vld), 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R5", "back to running", int'(status), 1);

    // R3/R4: issue queue full
    step(1, 32'hC1, 0, 0, 0, 1, 1);
    chk("R3", "full bundle not passed", int'(proc_vld), 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R3", "blocked on full", int'(status), 2);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R4", "full holds blocked", int'(status), 2);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R5", "single entry unblock", int'(status), 3);
    chk("R5", "single entry no stall", int'(up_stall), 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R5", "running after C", int'(status), 1);

    // R8: stall beats squash
    step(1, 32'hD1, 1, 1, 0, 0, 1);
    chk("R8", "no squash start", int'(sq_start), 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R8", "blocked not squashing", int'(status), 2);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R8", "recovered", int'(status), 1);

    // R6/R7: squash from Running
    step(1, 32'hE0, 0, 1, 0, 0, 0);
    chk("R6", "squash start", int'(sq_start), 1);
    chk("R6", "bundle dropped", int'(proc_vld), 0);
    step(1, 32'hE9, 0, 0, 1, 0, 0);
    chk("R7", "squashing status", int'(status), 4);
    chk("R7", "continue", int'(sq_cont), 1);
    chk("R7", "no stop yet", int'(sq_stop), 0);
    chk("R7", "no stall", int'(up_stall), 0);
    chk("R7", "ignored bundle", int'(proc_vld), 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R7", "stop pulse", int'(sq_stop), 1);
    chk("R7", "no continue", int'(sq_cont), 0);
    step(1, 32'hE1, 0, 0, 0, 0, 1);
    chk("R7", "running after stop", int'(status), 1);
    chk("R7", "stop one cycle", int'(sq_stop), 0);

    // R9: squash in Blocked flushes skid
    step(1, 32'hF1, 1, 0, 0, 0, 0);
    step(1, 32'hF2, 1, 1, 0, 0, 0);
    chk("R6", "start from blocked", int'(sq_start), 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R9", "squashing", int'(status), 4);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R9", "blocked again", int'(status), 2);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R9", "unblock empty", int'(status), 3);
    chk("R9", "no stale bundle", int'(proc_vld), 0);
    chk("R9", "no stall on empty", int'(up_stall), 0);

    // R10: overflow
    step(1, 32'h11, 1, 0, 0, 0, 1);
    step(1, 32'h12, 1, 0, 0, 0, 1);
    step(1, 32'h13, 1, 0, 0, 0, 1);
    step(1, 32'h14, 1, 0, 0, 0, 1);
    chk("R10", "no ovf at depth", int'(skid_ovf), 0);
    step(1, 32'h15, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R10", "ovf set", int'(skid_ovf), 1);
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R5", "drain vld", int'(proc_vld), 1);
    end
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R10", "ovf sticky", int'(skid_ovf), 1);
    chk("R5", "running after drain", int'(status), 1);

    repeat (3) step(0, 0, 0, 0, 0, 0, 0);
    chk("R5", "scoreboard empty", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule